// File: doc/BRIEF.md
# Peripheral Enable/Reset Sequencer

This block brings one peripheral up from the off state in a safe order and takes it back down on request. When an enable request arrives for a peripheral that has a reset line and is not already running, the sequencer holds the peripheral in reset and waits a short settle interval. It then turns the peripheral's clock on and waits a longer stabilisation interval with reset still held. Only after that does it release reset. Both intervals are parameters given in clock cycles.

A peripheral built without a reset line takes a shortcut: its clock is switched on at once. A disable request only stops the clock and leaves the reset control alone. A one-cycle `done_o` pulse marks the end of every accepted request. `busy_o` is high while a timed sequence runs, and any request that arrives during that time is dropped. The clock-enable output can be configured active-high or active-low for each instance, so gates whose enable bit is inverted can be driven directly.

Top module: `periph_enable_seq`

## Requirements
- R1: During and after synchronous reset, with no request yet made, the internal clock state is off, `busy_o` and `done_o` are 0, and `periph_rst_o` is 1 when HAS_RESET_LINE=1 or 0 when HAS_RESET_LINE=0.
- R2: With HAS_RESET_LINE=1, an enable request sampled at clock edge E0 while not enabled sets `periph_rst_o`=1 and `busy_o`=1 after E0, with the clock still off.
- R3: In that sequence the clock turns on after edge E0+SETTLE_CYCLES and not before, while `periph_rst_o` is still 1.
- R4: `periph_rst_o` falls and `done_o` pulses after edge E0+SETTLE_CYCLES+STABLE_CYCLES, with `busy_o` low in that same cycle. `periph_rst_o` stays 1 throughout the waits.
- R5: An enable request while already enabled (clock on and `periph_rst_o`=0) gives `done_o` after E0 and changes no other output.
- R6: With HAS_RESET_LINE=0, an enable request turns the clock on and pulses `done_o` after E0, and `periph_rst_o` is never 1.
- R7: A disable request in idle turns the clock off and pulses `done_o` after E0, and leaves `periph_rst_o` unchanged. This also applies when the clock is already off.
- R8: Enable or disable requests arriving while `busy_o`=1 are ignored: the running sequence finishes on its original schedule.
- R9: If enable and disable are both requested in the same idle cycle, the enable is performed.
- R10: With CLK_ACTIVE_LOW=1, `clk_gate_o` is 0 when the clock is on and 1 when it is off. With CLK_ACTIVE_LOW=0 it is 1 when on.
- R11: An enable request after a disable (clock off, reset released) runs the full sequence of R2 to R4 again, re-asserting reset first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req_i | input | 1 | Enable request, sampled when idle |
| dis_req_i | input | 1 | Disable request, sampled when idle |
| periph_rst_o | output | 1 | Peripheral reset control, 1 = held in reset |
| clk_gate_o | output | 1 | Peripheral clock gate control, polarity set by CLK_ACTIVE_LOW |
| busy_o | output | 1 | A timed enable sequence is running |
| done_o | output | 1 | One-cycle pulse when a request completes |

## Verification
Take the edge that samples a request as edge 0. Done for an immediate request (already enabled, no reset line, or disable) is due after edge 0. The clock of a full sequence is due after edge SETTLE_CYCLES. Reset release and done are due after edge SETTLE_CYCLES+STABLE_CYCLES. The bench drives requests on the falling edge and counts falling edges from the request until `done_o` is seen. It records the first cycle the clock appears and checks that reset and busy stay high on every intermediate sample. It compares these cycle numbers against values computed from the two wait parameters.

// File: rtl/pes_pkg.sv
// Package: shared types for the peripheral enable sequencer.
// Assumes: nothing; state encoding is internal to the block.
package pes_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETTLE = 2'd1,
        SQ_STABLE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pes_wait_cnt.sv
// Module: pes_wait_cnt
// Down-counter used to time the settle and stabilisation waits.
// Assumes: a load value of N-1 gives a wait of N cycles before zero_o is seen.
module pes_wait_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    // Load a new interval or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Zero flag for the sequencer.
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pes_fsm.sv
// Module: pes_fsm
// Sequencing state machine: reset assert, settle wait, clock on,
// stabilisation wait, reset release. Disable only stops the clock.
// Assumes: SETTLE_CYCLES and STABLE_CYCLES are at least 1 and fit in CW bits.
module pes_fsm
    import pes_pkg::*;
#(
    parameter bit HAS_RESET_LINE = 1'b1,
    parameter int SETTLE_CYCLES  = 4,
    parameter int STABLE_CYCLES  = 8,
    parameter int CW             = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_req_i,
    input  logic          dis_req_i,
    input  logic          cnt_zero_i,
    output logic          cnt_load_o,
    output logic [CW-1:0] cnt_val_o,
    output logic          clk_on_o,
    output logic          rst_on_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0] STABLE_LD = CW'(STABLE_CYCLES - 1);
    localparam logic          RST_INIT  = HAS_RESET_LINE;

    seq_state_t state_q;
    logic       clk_on_q, rst_on_q, done_q;
    logic       running;
    logic       start_seq;

    // Peripheral counts as enabled when clocked and out of reset.
    assign running   = clk_on_q && !rst_on_q;
    assign start_seq = (state_q == SQ_IDLE) && en_req_i && !running && HAS_RESET_LINE;

    // Counter load strobe and interval selection.
    always_comb begin
        cnt_load_o = start_seq || ((state_q == SQ_SETTLE) && cnt_zero_i);
        cnt_val_o  = (state_q == SQ_IDLE) ? SETTLE_LD : STABLE_LD;
    end

    // State, control outputs and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            clk_on_q <= 1'b0;
            rst_on_q <= RST_INIT;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (en_req_i) begin
                        if (running) begin
                            done_q <= 1'b1;
                        end else if (HAS_RESET_LINE) begin
                            rst_on_q <= 1'b1;
                            state_q  <= SQ_SETTLE;
                        end else begin
                            clk_on_q <= 1'b1;
                            done_q   <= 1'b1;
                        end
                    end else if (dis_req_i) begin
                        clk_on_q <= 1'b0;
                        done_q   <= 1'b1;
                    end
                end
                SQ_SETTLE: begin
                    if (cnt_zero_i) begin
                        clk_on_q <= 1'b1;
                        state_q  <= SQ_STABLE;
                    end
                end
                SQ_STABLE: begin
                    if (cnt_zero_i) begin
                        rst_on_q <= 1'b0;
                        done_q   <= 1'b1;
                        state_q  <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign clk_on_o = clk_on_q;
    assign rst_on_o = rst_on_q;
    assign busy_o   = (state_q != SQ_IDLE);
    assign done_o   = done_q;

    // R3: the clock may only come on while reset is held (reset-line variant).
    assert_clk_under_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_RESET_LINE && $rose(clk_on_q)) |-> rst_on_q);

    // R4: reset is released only with the clock running, and completion is flagged.
    assert_release_after_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_on_q) |-> (clk_on_q && done_q));

    // R7: an idle disable stops the clock and leaves reset as it was.
    assert_disable_keeps_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && dis_req_i && !en_req_i) |=> ($stable(rst_on_q) && !clk_on_q));

    // R8: during the settle wait requests change nothing.
    assert_settle_ignores_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SETTLE && !cnt_zero_i) |=>
            (state_q == SQ_SETTLE && $stable(clk_on_q) && rst_on_q));
endmodule

// File: rtl/pes_gate_drv.sv
// Module: pes_gate_drv
// Applies the per-instance enable polarity to the clock gate control.
// Assumes: clk_on_i is 1 when the peripheral clock should run.
module pes_gate_drv #(
    parameter bit CLK_ACTIVE_LOW = 1'b0
) (
    input  logic clk_on_i,
    output logic clk_gate_o
);
    generate
        if (CLK_ACTIVE_LOW) begin : g_low
            // Inverted gate: clearing the bit runs the clock.
            assign clk_gate_o = ~clk_on_i;
        end else begin : g_high
            // Direct gate: setting the bit runs the clock.
            assign clk_gate_o = clk_on_i;
        end
    endgenerate
endmodule

// File: rtl/periph_enable_seq.sv
// Module: periph_enable_seq (top)
// Sequences one peripheral's reset and clock controls on enable/disable requests.
// Assumes: wait parameters are in clock cycles, each at least 1.
module periph_enable_seq #(
    parameter bit HAS_RESET_LINE = 1'b1,
    parameter bit CLK_ACTIVE_LOW = 1'b0,
    parameter int SETTLE_CYCLES  = 25000,
    parameter int STABLE_CYCLES  = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req_i,
    input  logic dis_req_i,
    output logic periph_rst_o,
    output logic clk_gate_o,
    output logic busy_o,
    output logic done_o
);
    localparam int MAX_WAIT = (SETTLE_CYCLES > STABLE_CYCLES) ? SETTLE_CYCLES : STABLE_CYCLES;
    localparam int CW       = $clog2(MAX_WAIT + 1) + 1;

    logic          cnt_load, cnt_zero, clk_on;
    logic [CW-1:0] cnt_val;

    pes_wait_cnt #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .zero_o     (cnt_zero)
    );

    pes_fsm #(
        .HAS_RESET_LINE (HAS_RESET_LINE),
        .SETTLE_CYCLES  (SETTLE_CYCLES),
        .STABLE_CYCLES  (STABLE_CYCLES),
        .CW             (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_req_i   (en_req_i),
        .dis_req_i  (dis_req_i),
        .cnt_zero_i (cnt_zero),
        .cnt_load_o (cnt_load),
        .cnt_val_o  (cnt_val),
        .clk_on_o   (clk_on),
        .rst_on_o   (periph_rst_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    pes_gate_drv #(.CLK_ACTIVE_LOW(CLK_ACTIVE_LOW)) u_gate (
        .clk_on_i   (clk_on),
        .clk_gate_o (clk_gate_o)
    );
endmodule

// File: tb/tb_periph_enable_seq.sv
module tb_periph_enable_seq;
    localparam int S  = 3;
    localparam int T  = 7;
    localparam int NV = 7;
    // Vector table: request, then expected done latency and final outputs.
    localparam logic V_EN  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic V_DIS [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam int   V_LAT [NV] = '{S+T, 0, 0, S+T, 0, S+T, 0};
    localparam logic V_CLK [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic V_RST [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam string V_TAG [NV] = '{"R2/R3/R4", "R5", "R7", "R11", "R7", "R9", "R7"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, dis_req = 1'b0;
    logic en2 = 1'b0, dis2 = 1'b0;
    logic periph_rst, clk_gate, busy, done;
    logic rst2, gate2, busy2, done2;
    int   checks = 0, failures = 0, cycles = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    periph_enable_seq #(.HAS_RESET_LINE(1'b1), .CLK_ACTIVE_LOW(1'b0),
                        .SETTLE_CYCLES(S), .STABLE_CYCLES(T)) dut (
        .clk(clk), .rst_n(rst_n), .en_req_i(en_req), .dis_req_i(dis_req),
        .periph_rst_o(periph_rst), .clk_gate_o(clk_gate), .busy_o(busy), .done_o(done));

    periph_enable_seq #(.HAS_RESET_LINE(1'b0), .CLK_ACTIVE_LOW(1'b1),
                        .SETTLE_CYCLES(S), .STABLE_CYCLES(T)) dut_nr (
        .clk(clk), .rst_n(rst_n), .en_req_i(en2), .dis_req_i(dis2),
        .periph_rst_o(rst2), .clk_gate_o(gate2), .busy_o(busy2), .done_o(done2));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one request and observe until done; k counts edges after the sampling edge.
    task automatic do_req(input logic e, input logic d, input int mid_k,
                          output int lat, output int clk_k,
                          output bit rst_low, output bit busy_gap);
        @(negedge clk); en_req = e; dis_req = d;
        lat = -1; clk_k = -1; rst_low = 1'b0; busy_gap = 1'b0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            en_req  = (k == mid_k);
            dis_req = (k == mid_k);
            if (clk_gate && clk_k < 0) clk_k = k;
            if (done) begin lat = k; break; end
            if (!periph_rst) rst_low = 1'b1;
            if (!busy) busy_gap = 1'b1;
        end
        en_req = 1'b0; dis_req = 1'b0;
    endtask

    initial begin
        int lat, ck;
        bit rl, bg;
        repeat (3) @(negedge clk);
        // R1: reset state for both variants.
        check(clk_gate == 1'b0, "R1 clk off", clk_gate, 0);
        check(periph_rst == 1'b1, "R1 reset held", periph_rst, 1);
        check(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
        check(rst2 == 1'b0 && gate2 == 1'b1, "R1 no-reset variant", {rst2, gate2}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk on the reset-line instance.
        for (int v = 0; v < NV; v++) begin
            logic clk_before;
            clk_before = clk_gate;
            do_req(V_EN[v], V_DIS[v], -1, lat, ck, rl, bg);
            check(lat == V_LAT[v], {V_TAG[v], " done latency"}, lat, V_LAT[v]);
            check(clk_gate == V_CLK[v], {V_TAG[v], " final clock"}, clk_gate, V_CLK[v]);
            check(periph_rst == V_RST[v], {V_TAG[v], " final reset"}, periph_rst, V_RST[v]);
            check(busy == 1'b0, {V_TAG[v], " busy low at done"}, busy, 0);
            if (V_LAT[v] != 0) begin
                check(!clk_before && ck == S, {V_TAG[v], " R3 clock-on cycle"}, ck, S);
                check(!rl, {V_TAG[v], " R2/R4 reset held during waits"}, rl, 0);
                check(!bg, {V_TAG[v], " R2 busy during waits"}, bg, 0);
            end
        end

        // R8: requests mid-sequence are dropped (clock is off here after vector 6).
        do_req(1'b1, 1'b0, 4, lat, ck, rl, bg);
        check(lat == S + T, "R8 latency unchanged by busy requests", lat, S + T);
        check(clk_gate == 1'b1 && periph_rst == 1'b0, "R8 sequence finished",
              {clk_gate, periph_rst}, 2'b10);
        // R8: after completion one idle cycle shows no stray done.
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8 no extra completion", {done, busy}, 0);

        // R6/R10: no-reset-line, active-low instance.
        @(negedge clk); en2 = 1'b1;
        @(negedge clk); en2 = 1'b0;
        check(done2 == 1'b1, "R6 done after one edge", done2, 1);
        check(gate2 == 1'b0, "R10 active-low gate on", gate2, 0);
        check(rst2 == 1'b0 && busy2 == 1'b0, "R6 reset never asserted", {rst2, busy2}, 0);
        @(negedge clk); dis2 = 1'b1;
        @(negedge clk); dis2 = 1'b0;
        check(done2 == 1'b1 && gate2 == 1'b1, "R7/R10 active-low gate off", {done2, gate2}, 2'b11);
        check(rst2 == 1'b0, "R7 reset untouched", rst2, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule